// File: doc/BRIEF.md
# Self-configuring host bus front end

This block sits between a host processor bus and the register files of a two-channel peripheral. It does not know at power-up how it is wired to the host. It learns this from the first write after reset. That write is consumed as a bus-configuration write and is never passed on to a channel. From that write the block decides three things:

- whether addresses arrive multiplexed on the AD lines and are qualified by an address strobe;
- whether the bus is an 8-bit data path with a separate address byte;
- which sense its wait/ready output drives.

These decisions stay fixed until the next reset.

Once configured, every access produces exactly one register-access request, whichever strobe style the host uses. An access is started either by a data strobe with a read/write level, or by separate read and write strobes. Each request carries:

- the direction;
- the channel addressed;
- whether the data registers are addressed directly;
- the register address and the write data;
- flags for interrupt-acknowledge and fly-by DMA cycles. Chip select is not needed for these two cycle types.

All strobes are active low and asynchronous to the block clock. They are synchronized, and each access is detected on its leading edge.

Top module: `hbi_top`

## Requirements
- R1: After reset, cfg_done, mux_mode, bus8_sep, wait_pol and req_valid are all 0, and waitrdy idles at 1.
- R2: The first write after reset, at any address, sets cfg_done and produces no request (req_valid stays 0).
- R3: mux_mode is set to 1 when as_n was low at any time after reset up to and including the leading edge of the configuration write. Otherwise it is set to 0.
- R4: bus8_sep is set to 1 only if all of the following hold during the configuration write:
  - mux_mode is 0;
  - ad[2] is 0;
  - ad[15] is 1;
  - ad[14:8] are all 0.
  In every other case bus8_sep is set to 0.
- R5: wait_pol takes the level of ab_sel during the configuration write. When wait_pol is 1, waitrdy equals req_valid. When wait_pol is 0, waitrdy is the inverse of req_valid.
- R6: Writes after the configuration write are decoded as normal accesses and leave cfg_done, mux_mode, bus8_sep and wait_pol unchanged.
- R7: In multiplexed mode, ad[7:0] and cs_n are captured on the rising edge of as_n. The request uses the captured address and the captured chip select, and cs_n at the time of the strobe is ignored.
- R8: In non-multiplexed mode, as_n has no effect, and the address and write data depend on the bus type:
  - with bus8_sep set, req_addr is ad[15:8] and req_wdata is {8'h00, ad[7:0]};
  - otherwise req_addr is 0 and req_wdata is ad.
- R9: An ordinary access with chip select deasserted produces no request. Chip select is ignored when sitack_n is low on a read, or when dack_n is low; a DMA request reports req_dma=1.
- R10: req_chan_a equals ab_sel (1 for channel A, 0 for channel B), and req_data equals dc_sel (1 for direct access to the data registers).
- R11: Direction is taken from the strobes:
  - rd_n low gives a read;
  - wr_n low gives a write;
  - ds_n low with rw=1 gives a read, and ds_n low with rw=0 gives a write.
  Each access produces exactly one single-cycle req_valid pulse, and req_write=1 marks a write.
- R12: A read with sitack_n low produces a request with req_vec=1 and req_write=0.
- R13: Accesses before the configuration write, reads included, produce no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rw | input | 1 | Direction with ds_n: 1 read, 0 write |
| cs_n | input | 1 | Chip select, active low |
| ab_sel | input | 1 | Channel select: 1 channel A, 0 channel B |
| dc_sel | input | 1 | 1 selects direct data-register access |
| sitack_n | input | 1 | Interrupt-acknowledge cycle, active low |
| dack_n | input | 1 | Fly-by DMA cycle, active low |
| ad | input | 16 | Address/data lines |
| cfg_done | output | 1 | Configuration write taken |
| mux_mode | output | 1 | Multiplexed bus selected |
| bus8_sep | output | 1 | 8-bit bus with separate address selected |
| wait_pol | output | 1 | Sense of waitrdy |
| waitrdy | output | 1 | Wait/ready output |
| req_valid | output | 1 | One-cycle register-access request |
| req_write | output | 1 | Request is a write |
| req_chan_a | output | 1 | Request targets channel A |
| req_data | output | 1 | Request targets data registers directly |
| req_vec | output | 1 | Request is an interrupt-vector read |
| req_dma | output | 1 | Request is a fly-by DMA transfer |
| req_addr | output | 8 | Register address |
| req_wdata | output | 16 | Write data |

## Verification
The assertions assume the following about the host:

- rw, cs_n, ab_sel, dc_sel, sitack_n, dack_n and ad are stable for at least two clocks before a strobe falls, and stay stable while the strobe is low;
- only one strobe style is used in any one access;
- strobes are held low, and then high, for several clocks;
- in multiplexed mode, the address phase finishes before the data strobe.

The bench drives every input at falling clock edges with those margins. It always completes an address-strobe pulse before the next data phase, except in the case that deliberately lowers as_n together with the configuration write strobe.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef struct packed {
    logic write;
    logic chan_a;
    logic data_sel;
    logic vec;
    logic dma;
  } req_flags_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [STAGES:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl = stg[STAGES-1];
  assign prv = stg[STAGES];
endmodule

// File: rtl/hbi_cfg.sv
module hbi_cfg #(
  parameter int AD_W = 16,
  localparam int HALF = AD_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_write,
  input  logic            as_low,
  input  logic            ab_sel,
  input  logic            ad_bit2,
  input  logic [HALF-1:0] ad_hi,
  output logic            cfg_done,
  output logic            mux_mode,
  output logic            bus8_sep,
  output logic            wait_pol
);
  logic as_seen_q, as_seen_d;
  logic done_d, mux_d, bus8_d, pol_d;
  logic take;

  assign take = start & is_write & ~cfg_done;

  always_comb begin
    as_seen_d = as_seen_q | (as_low & ~cfg_done);
    done_d    = cfg_done;
    mux_d     = mux_mode;
    bus8_d    = bus8_sep;
    pol_d     = wait_pol;
    if (take) begin
      done_d = 1'b1;
      mux_d  = as_seen_q | as_low;
      bus8_d = ~(as_seen_q | as_low) & ~ad_bit2 & ad_hi[HALF-1]
               & (ad_hi[HALF-2:0] == '0);
      pol_d  = ab_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_seen_q <= 1'b0;
      cfg_done  <= 1'b0;
      mux_mode  <= 1'b0;
      bus8_sep  <= 1'b0;
      wait_pol  <= 1'b0;
    end else begin
      as_seen_q <= as_seen_d;
      cfg_done  <= done_d;
      mux_mode  <= mux_d;
      bus8_sep  <= bus8_d;
      wait_pol  <= pol_d;
    end
  end

  // R6: once configured, the decisions are frozen
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && $stable(mux_mode) && $stable(bus8_sep) && $stable(wait_pol)));
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
  import hbi_pkg::*;
#(
  parameter int AD_W = 16,
  localparam int HALF = AD_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_write,
  input  logic            as_rise,
  input  logic            cfg_done,
  input  logic            mux_mode,
  input  logic            bus8_sep,
  input  logic            cs_n,
  input  logic            ab_sel,
  input  logic            dc_sel,
  input  logic            sitack_n,
  input  logic            dack_n,
  input  logic [AD_W-1:0] ad,
  output logic            req_valid,
  output req_flags_t      req_flags,
  output logic [HALF-1:0] req_addr,
  output logic [AD_W-1:0] req_wdata
);
  logic [HALF-1:0] lat_addr_q, lat_addr_d;
  logic            lat_cs_n_q, lat_cs_n_d;
  logic            cs_ok, vec, dma, take;
  req_flags_t      flags_d;
  logic [HALF-1:0] addr_d;
  logic [AD_W-1:0] wdata_d;

  always_comb begin
    lat_addr_d = as_rise ? ad[HALF-1:0] : lat_addr_q;
    lat_cs_n_d = as_rise ? cs_n : lat_cs_n_q;
    cs_ok      = mux_mode ? ~lat_cs_n_q : ~cs_n;
    vec        = ~sitack_n & ~is_write;
    dma        = ~dack_n;
    take       = start & cfg_done & (cs_ok | vec | dma);
    flags_d    = req_flags;
    addr_d     = req_addr;
    wdata_d    = req_wdata;
    if (take) begin
      flags_d = '{write: is_write, chan_a: ab_sel, data_sel: dc_sel, vec: vec, dma: dma};
      if (mux_mode)      addr_d = lat_addr_q;
      else if (bus8_sep) addr_d = ad[AD_W-1:HALF];
      else               addr_d = '0;
      wdata_d = bus8_sep ? {{HALF{1'b0}}, ad[HALF-1:0]} : ad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr_q <= '0;
      lat_cs_n_q <= 1'b1;
      req_valid  <= 1'b0;
      req_flags  <= '0;
      req_addr   <= '0;
      req_wdata  <= '0;
    end else begin
      lat_addr_q <= lat_addr_d;
      lat_cs_n_q <= lat_cs_n_d;
      req_valid  <= take;
      req_flags  <= flags_d;
      req_addr   <= addr_d;
      req_wdata  <= wdata_d;
    end
  end

  // R11: one access gives a single-cycle pulse
  p_single_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R12: a vector fetch is always a read
  p_vec_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_flags.vec) |-> !req_flags.write);
  // R13: nothing is issued before configuration
  p_no_req_unconfigured_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !req_valid);
endmodule

// File: rtl/hbi_top.sv
module hbi_top
  import hbi_pkg::*;
#(
  parameter int AD_W        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HALF = AD_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_n,
  input  logic            ds_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            rw,
  input  logic            cs_n,
  input  logic            ab_sel,
  input  logic            dc_sel,
  input  logic            sitack_n,
  input  logic            dack_n,
  input  logic [AD_W-1:0] ad,
  output logic            cfg_done,
  output logic            mux_mode,
  output logic            bus8_sep,
  output logic            wait_pol,
  output logic            waitrdy,
  output logic            req_valid,
  output logic            req_write,
  output logic            req_chan_a,
  output logic            req_data,
  output logic            req_vec,
  output logic            req_dma,
  output logic [HALF-1:0] req_addr,
  output logic [AD_W-1:0] req_wdata
);
  localparam int I_WR = 0;
  localparam int I_RD = 1;
  localparam int I_DS = 2;
  localparam int I_AS = 3;

  logic [3:0] stb_lvl, stb_prv;
  logic       act_now, act_prev, start, is_write, as_rise, as_low;
  req_flags_t flags;

  hbi_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({as_n, ds_n, rd_n, wr_n}),
    .lvl(stb_lvl), .prv(stb_prv));

  assign act_now  = ~(stb_lvl[I_DS] & stb_lvl[I_RD] & stb_lvl[I_WR]);
  assign act_prev = ~(stb_prv[I_DS] & stb_prv[I_RD] & stb_prv[I_WR]);
  assign start    = act_now & ~act_prev;
  assign is_write = ~stb_lvl[I_WR] | (~stb_lvl[I_DS] & ~rw);
  assign as_low   = ~stb_lvl[I_AS];
  assign as_rise  = stb_lvl[I_AS] & ~stb_prv[I_AS];

  hbi_cfg #(.AD_W(AD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .as_low(as_low), .ab_sel(ab_sel), .ad_bit2(ad[2]), .ad_hi(ad[AD_W-1:HALF]),
    .cfg_done(cfg_done), .mux_mode(mux_mode), .bus8_sep(bus8_sep),
    .wait_pol(wait_pol));

  hbi_decode #(.AD_W(AD_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .as_rise(as_rise), .cfg_done(cfg_done), .mux_mode(mux_mode),
    .bus8_sep(bus8_sep), .cs_n(cs_n), .ab_sel(ab_sel), .dc_sel(dc_sel),
    .sitack_n(sitack_n), .dack_n(dack_n), .ad(ad),
    .req_valid(req_valid), .req_flags(flags), .req_addr(req_addr),
    .req_wdata(req_wdata));

  assign req_write  = flags.write;
  assign req_chan_a = flags.chan_a;
  assign req_data   = flags.data_sel;
  assign req_vec    = flags.vec;
  assign req_dma    = flags.dma;
  assign waitrdy    = wait_pol ? req_valid : ~req_valid;

  // R2: the configuring write is never forwarded
  p_cfg_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> !req_valid);
endmodule

// File: tb/hbi_top_bench.sv
`timescale 1ns/1ps
module hbi_top_bench;
  logic clk, rst_n;
  logic as_n, ds_n, rd_n, wr_n, rw, cs_n, ab_sel, dc_sel, sitack_n, dack_n;
  logic [15:0] ad;
  logic cfg_done, mux_mode, bus8_sep, wait_pol, waitrdy, req_valid;
  logic req_write, req_chan_a, req_data, req_vec, req_dma;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;

  int checks = 0, fails = 0, nreq = 0;
  logic cap_wr;
  logic cap_wait;
  bit done = 0;

  hbi_top u_hbi_top (.*);

  initial clk = 0;
  always #10 clk = ~clk;

  always @(negedge clk) if (req_valid) begin
    nreq++;
    cap_wait = waitrdy;
    cap_wr   = req_write;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    as_n = 1; ds_n = 1; rd_n = 1; wr_n = 1; rw = 1; cs_n = 1;
    ab_sel = 0; dc_sel = 0; sitack_n = 1; dack_n = 1; ad = 0;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // which: 0 wr_n, 1 rd_n, 2 ds_n
  task automatic strobe(int which);
    @(negedge clk);
    case (which) 0: wr_n = 0; 1: rd_n = 0; default: ds_n = 0; endcase
    repeat (6) @(negedge clk);
    wr_n = 1; rd_n = 1; ds_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic as_pulse(logic [15:0] a, logic c);
    ad = a; cs_n = c;
    @(negedge clk); as_n = 0;
    repeat (5) @(negedge clk); as_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cfg_done", cfg_done, 0);
    chk("R1 mux_mode", mux_mode, 0);
    chk("R1 bus8_sep", bus8_sep, 0);
    chk("R1 wait_pol", wait_pol, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 waitrdy", waitrdy, 1);
  endtask

  task automatic t_nonmux();
    int n0;
    do_reset();
    n0 = nreq; cs_n = 0; strobe(1);
    chk("R13 read before config", nreq - n0, 0);
    chk("R13 still unconfigured", cfg_done, 0);
    ad = 16'h8000; ab_sel = 1; cs_n = 0; n0 = nreq; strobe(0);
    chk("R2 cfg_done", cfg_done, 1);
    chk("R2 no request", nreq - n0, 0);
    chk("R3 nonmux", mux_mode, 0);
    chk("R4 bus8 selected", bus8_sep, 1);
    chk("R5 wait_pol", wait_pol, 1);
    chk("R5 waitrdy idle", waitrdy, 0);
    ad = 16'h3C5A; ab_sel = 0; dc_sel = 1; cs_n = 0; n0 = nreq; strobe(0);
    chk("R11 one request", nreq - n0, 1);
    chk("R11 write", req_write, 1);
    chk("R8 addr", req_addr, 8'h3C);
    chk("R8 wdata", req_wdata, 16'h005A);
    chk("R10 chan B", req_chan_a, 0);
    chk("R10 data sel", req_data, 1);
    chk("R5 waitrdy at request", cap_wait, 1);
    as_pulse(16'h7700, 1);
    ad = 16'h1122; cs_n = 0; ab_sel = 1; dc_sel = 0; n0 = nreq; strobe(1);
    chk("R8 AS ignored count", nreq - n0, 1);
    chk("R8 AS ignored addr", req_addr, 8'h11);
    chk("R10 chan A", req_chan_a, 1);
    chk("R11 rd read", req_write, 0);
    ad = 16'h0004; ab_sel = 0; cs_n = 0; strobe(0);
    chk("R6 mux kept", mux_mode, 0);
    chk("R6 bus8 kept", bus8_sep, 1);
    chk("R6 pol kept", wait_pol, 1);
    cs_n = 1; n0 = nreq; strobe(0);
    chk("R9 cs deasserted", nreq - n0, 0);
    sitack_n = 0; n0 = nreq; strobe(1);
    chk("R12 vec count", nreq - n0, 1);
    chk("R12 vec flag", req_vec, 1);
    chk("R12 vec read", req_write, 0);
    sitack_n = 1; dack_n = 0; n0 = nreq; strobe(0);
    chk("R9 dma count", nreq - n0, 1);
    chk("R9 dma flag", req_dma, 1);
    dack_n = 1; cs_n = 0; rw = 1; n0 = nreq; strobe(2);
    chk("R11 ds read count", nreq - n0, 1);
    chk("R11 ds read", req_write, 0);
    rw = 0; n0 = nreq; strobe(2);
    chk("R11 ds write count", nreq - n0, 1);
    chk("R11 ds write", req_write, 1);
    idle();
  endtask

  task automatic t_mux();
    int n0;
    do_reset();
    as_pulse(16'h0000, 0);
    ad = 16'h8000; ab_sel = 0; strobe(0);
    chk("R3 mux", mux_mode, 1);
    chk("R4 no bus8 in mux", bus8_sep, 0);
    chk("R5 pol0", wait_pol, 0);
    as_pulse(16'h0077, 0);
    ad = 16'h1234; cs_n = 1; n0 = nreq; strobe(0);
    chk("R7 latched cs", nreq - n0, 1);
    chk("R7 latched addr", req_addr, 8'h77);
    chk("R7 wdata", req_wdata, 16'h1234);
    chk("R5 waitrdy active low", cap_wait, 0);
    as_pulse(16'h0055, 1);
    ad = 16'h0000; cs_n = 0; n0 = nreq; strobe(0);
    chk("R7 latched cs high", nreq - n0, 0);
    idle();
  endtask

  task automatic t_as_during();
    do_reset();
    ad = 16'h8000;
    @(negedge clk); wr_n = 0; as_n = 0;
    repeat (6) @(negedge clk); wr_n = 1; as_n = 1;
    repeat (6) @(negedge clk);
    chk("R3 AS during write", mux_mode, 1);
    do_reset();
    ad = 16'h8004; strobe(0);
    chk("R4 bit2 set no bus8", bus8_sep, 0);
    chk("R3 no AS nonmux", mux_mode, 0);
    chk("R8 plain nonmux", cfg_done, 1);
    ad = 16'hABCD; cs_n = 0; strobe(0);
    chk("R8 plain addr", req_addr, 0);
    chk("R8 plain wdata", req_wdata, 16'hABCD);
    idle();
  endtask

  initial begin
    t_reset();
    t_nonmux();
    t_mux();
    t_as_during();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule